// File: doc/BRIEF.md
# Protection Region Access Checker

This block decides whether a single memory access may proceed, given a table of protection entries. Each entry carries a configuration byte and a word-granular address register. The checker decodes every entry's matching mode in parallel, finds the lowest-numbered entry whose region contains the access, and then applies permission and lock rules. These rules depend on the access kind (load, store, or fetch) and on whether the requester runs at machine level or at a lower level.

The entry table is held elsewhere and presented flat on the ports. The verdict is a single registered `grant` bit, due one clock after the inputs are presented. A trap unit or a bus gate downstream consumes it. Storage of the entries, trap generation and memory-attribute checks live outside this block.

Top module: `prot_access_check`

## Requirements
- R1: Each entry's configuration byte is decoded as: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 matching mode, bit 7 lock. Bits 6:5 have no effect on the verdict.
- R2: Mode code 0 (off) makes the entry match no address.
- R3: Mode code 1 (top of range) matches word addresses `w` with `prev <= w < own`. Here `own` is this entry's address register and `prev` is the previous entry's register, or zero for entry 0.
- R4: Mode code 2 matches exactly the one aligned four-byte word whose word address equals the entry's address register.
- R5: Mode code 3 matches an aligned power-of-two region. When the address register ends in k ones, the region is 2^(k+3) bytes wide. A register of all ones covers the whole address space.
- R6: When several entries match, only the lowest-numbered one decides the verdict.
- R7: Access kind 00 (load) needs the read bit, 01 (store) needs the write bit, and 10 (fetch) needs the execute bit. Kind 11 is always denied.
- R8: A machine-level access that matches an unlocked entry is granted, whatever that entry's permission bits say.
- R9: A machine-level access that matches a locked entry is granted only if that entry has the needed permission bit.
- R10: When no entry matches, a machine-level access is granted. A lower-level access is denied if any entry has a mode other than off, and granted if every entry is off.
- R11: `grant` is registered. It reflects the inputs present at the previous rising clock edge, and a synchronous active-high reset forces it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | PA_W | Byte address of the access |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 invalid |
| acc_mach | input | 1 | 1 when the requester runs at machine level |
| ent_cfg | input | 8*N_ENT | Configuration bytes; entry i at bits [8i+7:8i] |
| ent_addr | input | (PA_W-2)*N_ENT | Word address registers; entry i at slice i |
| grant | output | 1 | Registered verdict: 1 allow, 0 fault |

## Verification
Every verdict is due exactly one rising edge after its inputs are applied. The bench changes inputs on a falling edge and samples `grant` on the following falling edge, so exactly one capturing edge lies between stimulus and check. A dedicated scenario probes `grant` shortly after new inputs are applied, before the next rising edge. It expects the previous verdict there, which confirms the output is not combinational. Reset behaviour is sampled while reset is held, with inputs present that would otherwise grant.

// File: rtl/prot_chk_pkg.sv
`timescale 1ns/1ps
package prot_chk_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_BAD   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } ent_cfg_t;

endpackage

// File: rtl/prot_region_match.sv
`timescale 1ns/1ps
module prot_region_match
  import prot_chk_pkg::*;
#(
  parameter int WA_W = 30
) (
  input  match_mode_e     mode,
  input  logic [WA_W-1:0] own_addr,
  input  logic [WA_W-1:0] low_addr,
  input  logic [WA_W-1:0] word,
  output logic            hit
);

  logic [WA_W-1:0] own_inc;
  logic [WA_W-1:0] care;

  // trailing ones plus the first zero become don't-care bits
  assign own_inc = own_addr + WA_W'(1);
  assign care    = ~(own_addr ^ own_inc);

  always_comb begin
    unique case (mode)
      MODE_OFF:   hit = 1'b0;
      MODE_TOR:   hit = (word >= low_addr) && (word < own_addr);
      MODE_NA4:   hit = (word == own_addr);
      MODE_NAPOT: hit = ((word & care) == (own_addr & care));
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/prot_first_hit.sv
`timescale 1ns/1ps
module prot_first_hit #(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] hits,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);

  // scan downward so the lowest index is written last
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prot_access_check.sv
`timescale 1ns/1ps
module prot_access_check
  import prot_chk_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int PA_W  = 32,
  localparam int WA_W  = PA_W - 2,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PA_W-1:0]         acc_addr,
  input  logic [1:0]              acc_kind,
  input  logic                    acc_mach,
  input  logic [8*N_ENT-1:0]      ent_cfg,
  input  logic [WA_W*N_ENT-1:0]   ent_addr,
  output logic                    grant
);

  ent_cfg_t         cfg_arr  [N_ENT];
  logic [WA_W-1:0]  addr_arr [N_ENT];
  logic [N_ENT-1:0] hits;
  logic [N_ENT-1:0] active;
  logic [WA_W-1:0]  word;
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  ent_cfg_t         win;
  logic             need_ok;
  logic             verdict;
  logic             unused_bits;

  assign word = acc_addr[PA_W-1:2];

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_ent
      logic [WA_W-1:0] low;
      assign cfg_arr[g]  = ent_cfg_t'(ent_cfg[8*g +: 8]);
      assign addr_arr[g] = ent_addr[WA_W*g +: WA_W];
      assign active[g]   = (cfg_arr[g].mode != MODE_OFF);
      if (g == 0) begin : g_first
        assign low = '0;
      end else begin : g_rest
        assign low = ent_addr[WA_W*(g-1) +: WA_W];
      end
      prot_region_match #(.WA_W(WA_W)) u_match (
        .mode     (cfg_arr[g].mode),
        .own_addr (addr_arr[g]),
        .low_addr (low),
        .word     (word),
        .hit      (hits[g])
      );
    end
  endgenerate

  prot_first_hit #(.N_ENT(N_ENT)) u_pick (
    .hits    (hits),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  assign win = cfg_arr[win_idx];

  always_comb begin
    unique case (acc_kind_e'(acc_kind))
      KIND_LOAD:  need_ok = win.r;
      KIND_STORE: need_ok = win.w;
      KIND_FETCH: need_ok = win.x;
      default:    need_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (acc_kind == KIND_BAD)
      verdict = 1'b0;
    else if (any_hit)
      verdict = (acc_mach && !win.lock) ? 1'b1 : need_ok;
    else
      verdict = acc_mach || !(|active);
  end

  always_ff @(posedge clk) begin
    if (rst) grant <= 1'b0;
    else     grant <= verdict;
  end

  always_comb begin
    unused_bits = ^acc_addr[1:0];
    for (int i = 0; i < N_ENT; i++) unused_bits = unused_bits ^ (^cfg_arr[i].rsvd);
  end

endmodule

// File: rtl/prot_access_check_sva.sv
`timescale 1ns/1ps
module prot_access_check_sva #(
  parameter int N_ENT = 4,
  parameter int PA_W  = 32,
  localparam int WA_W = PA_W - 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [PA_W-1:0]       acc_addr,
  input logic [1:0]            acc_kind,
  input logic                  acc_mach,
  input logic [8*N_ENT-1:0]    ent_cfg,
  input logic [WA_W*N_ENT-1:0] ent_addr,
  input logic                  grant
);

  logic       all_off;
  logic [7:0] e0;
  logic       e0_cover_all;
  logic       unused_sva;

  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < N_ENT; i++)
      if (ent_cfg[8*i+3 +: 2] != 2'b00) all_off = 1'b0;
  end

  assign e0           = ent_cfg[7:0];
  assign e0_cover_all = (e0[4:3] == 2'b11) && (&ent_addr[WA_W-1:0]);
  assign unused_sva   = ^acc_addr;

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> !grant);

  assert_bad_kind_denied_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b11) |=> !grant);

  assert_nomatch_mach_ok_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_mach && acc_kind != 2'b11 && all_off) |=> grant);

  assert_all_off_user_ok_R2: assert property (@(posedge clk) disable iff (rst)
    (!acc_mach && acc_kind != 2'b11 && all_off) |=> grant);

  assert_unlocked_mach_ok_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_mach && acc_kind != 2'b11 && e0_cover_all && !e0[7]) |=> grant);

  assert_locked_mach_read_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_mach && acc_kind == 2'b00 && e0_cover_all && e0[7] && !e0[0]) |=> !grant);

endmodule

bind prot_access_check prot_access_check_sva #(.N_ENT(N_ENT), .PA_W(PA_W)) u_sva (.*);

// File: tb/prot_access_check_test.sv
`timescale 1ns/1ps
module prot_access_check_test;

  localparam int N_ENT = 4;
  localparam int PA_W  = 32;
  localparam int WA_W  = PA_W - 2;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [PA_W-1:0]       acc_addr;
  logic [1:0]            acc_kind;
  logic                  acc_mach;
  logic [8*N_ENT-1:0]    ent_cfg;
  logic [WA_W*N_ENT-1:0] ent_addr;
  logic                  grant;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, EX = 2'b10, BAD = 2'b11;

  always #2.5 clk = ~clk;

  prot_access_check #(.N_ENT(N_ENT), .PA_W(PA_W)) uut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_mach(acc_mach), .ent_cfg(ent_cfg), .ent_addr(ent_addr), .grant(grant)
  );

  function automatic logic [7:0] mk(input logic l, input logic [1:0] m,
                                    input logic x, input logic w, input logic r);
    return {l, 2'b00, m, x, w, r};
  endfunction

  task automatic clear_all();
    ent_cfg  = '0;
    ent_addr = '0;
  endtask

  task automatic set_ent(input int i, input logic [7:0] c, input logic [WA_W-1:0] wa);
    ent_cfg[8*i +: 8]     = c;
    ent_addr[WA_W*i +: WA_W] = wa;
  endtask

  task automatic note(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic expect_grant(input logic [PA_W-1:0] a, input logic [1:0] k,
                              input logic m, input logic exp, input string tag);
    @(negedge clk);
    acc_addr = a; acc_kind = k; acc_mach = m;
    @(negedge clk);
    note(grant, exp, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; clear_all();
    acc_addr = 32'h100; acc_kind = LD; acc_mach = 1'b1;
    repeat (3) @(negedge clk);
    note(grant, 1'b0, "R11 reset holds grant low");
    rst = 1'b0;
  endtask

  task automatic t_all_off();
    clear_all();
    set_ent(0, mk(1'b0, 2'd0, 1'b0, 1'b0, 1'b0), 30'h40);
    expect_grant(32'h100, LD, 1'b0, 1'b1, "R2 off entry matches nothing, user allowed");
    expect_grant(32'h100, ST, 1'b1, 1'b1, "R10 all off, machine allowed");
  endtask

  task automatic t_tor();
    clear_all();
    set_ent(0, mk(1'b0, 2'd1, 1'b0, 1'b0, 1'b1), 30'h400);
    set_ent(1, mk(1'b0, 2'd1, 1'b0, 1'b1, 1'b1), 30'h800);
    expect_grant(32'h0000, LD, 1'b0, 1'b1, "R3 entry0 lower bound zero");
    expect_grant(32'h0FFC, ST, 1'b0, 1'b0, "R3 entry0 store without write bit");
    expect_grant(32'h1000, ST, 1'b0, 1'b1, "R3 entry1 lower bound inclusive");
    expect_grant(32'h2000, LD, 1'b0, 1'b0, "R3 upper bound exclusive, R10 user no match");
  endtask

  task automatic t_na4();
    clear_all();
    set_ent(0, mk(1'b0, 2'd2, 1'b0, 1'b0, 1'b1), 30'hC00);
    expect_grant(32'h3003, LD, 1'b0, 1'b1, "R4 byte inside word");
    expect_grant(32'h3004, LD, 1'b0, 1'b0, "R4 next word no match");
    expect_grant(32'h2FFC, LD, 1'b0, 1'b0, "R4 prior word no match");
  endtask

  task automatic t_napot();
    clear_all();
    set_ent(0, mk(1'b0, 2'd3, 1'b1, 1'b0, 1'b1), 30'h1001);
    expect_grant(32'h400C, EX, 1'b0, 1'b1, "R5 16-byte region last word");
    expect_grant(32'h4010, EX, 1'b0, 1'b0, "R5 past region end");
    expect_grant(32'h3FFC, EX, 1'b0, 1'b0, "R5 before region start");
    expect_grant(32'h4000, ST, 1'b0, 1'b0, "R7 store needs write bit");
    set_ent(0, mk(1'b0, 2'd3, 1'b0, 1'b0, 1'b1), '1);
    expect_grant(32'hFFFF_FFF0, LD, 1'b0, 1'b1, "R5 all-ones covers top");
    expect_grant(32'h0000_0000, LD, 1'b0, 1'b1, "R5 all-ones covers bottom");
    expect_grant(32'h0000_0000, EX, 1'b0, 1'b0, "R7 fetch needs execute bit");
  endtask

  task automatic t_priority();
    clear_all();
    set_ent(0, mk(1'b0, 2'd2, 1'b0, 1'b0, 1'b0), 30'h1400);
    set_ent(1, mk(1'b0, 2'd3, 1'b1, 1'b1, 1'b1), '1);
    expect_grant(32'h5000, LD, 1'b0, 1'b0, "R6 lower entry denies");
    expect_grant(32'h5004, LD, 1'b0, 1'b1, "R6 falls to entry1");
  endtask

  task automatic t_machine();
    clear_all();
    set_ent(0, mk(1'b0, 2'd2, 1'b0, 1'b0, 1'b0), 30'h1800);
    expect_grant(32'h6000, LD, 1'b1, 1'b1, "R8 unlocked ignores bits");
    set_ent(0, mk(1'b1, 2'd2, 1'b0, 1'b0, 1'b0), 30'h1800);
    expect_grant(32'h6000, LD, 1'b1, 1'b0, "R9 locked no read");
    expect_grant(32'h7000, LD, 1'b1, 1'b1, "R10 machine no match allowed");
    set_ent(0, mk(1'b1, 2'd2, 1'b0, 1'b0, 1'b1), 30'h1800);
    expect_grant(32'h6000, LD, 1'b1, 1'b1, "R9 locked with read");
    expect_grant(32'h6000, ST, 1'b1, 1'b0, "R9 locked no write");
  endtask

  task automatic t_bad_kind();
    clear_all();
    set_ent(0, mk(1'b0, 2'd3, 1'b1, 1'b1, 1'b1), '1);
    expect_grant(32'h10, BAD, 1'b0, 1'b0, "R7 kind 11 user denied");
    expect_grant(32'h10, BAD, 1'b1, 1'b0, "R7 kind 11 machine denied");
  endtask

  task automatic t_rsvd_bits();
    clear_all();
    set_ent(0, mk(1'b0, 2'd2, 1'b0, 1'b0, 1'b1) | 8'h60, 30'hC00);
    expect_grant(32'h3000, LD, 1'b0, 1'b1, "R1 reserved bits ignored, read");
    expect_grant(32'h3000, ST, 1'b0, 1'b0, "R1 reserved bits ignored, store");
  endtask

  task automatic t_latency();
    clear_all();
    set_ent(0, mk(1'b0, 2'd2, 1'b0, 1'b0, 1'b1), 30'hC00);
    expect_grant(32'h3000, LD, 1'b0, 1'b1, "R11 setup grant");
    @(negedge clk);
    acc_addr = 32'h3004;
    #1;
    note(grant, 1'b1, "R11 no change before edge");
    @(negedge clk);
    note(grant, 1'b0, "R11 change after one edge");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: grant=%0b expected=done", grant);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_all_off();
    t_tor();
    t_na4();
    t_napot();
    t_priority();
    t_machine();
    t_bad_kind();
    t_rsvd_bits();
    t_latency();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule